// File: doc/BRIEF.md
# Floating-Point Load/Store Decoder and Address Unit

This block accepts one 32-bit instruction word at a time together with the two general-register values the instruction names and the 64-bit register image to be stored. It sorts the word into one of four kinds: a floating-point memory access, a store of a floating register's low word as an integer, a trap, or something it does not handle. For memory accesses it forms the effective address, issues a single request carrying the direction and size, and waits for the memory to answer.

When a load returns, the unit produces the value to write into the floating register file. Single-precision data is widened to double format first, since floating registers always hold doubles. Update forms also hand back the effective address for the base register. An update form whose base field is zero is flagged as illegal. It then completes without touching memory or either register file.

Rounding a double down to single precision for a store belongs to the caller. The unit stores the low 32 bits of the supplied store image whenever the access is 4 bytes wide.

Top module: `fpls_unit`

## Requirements
- R1: `done_kind` reports the class of the finished instruction: 0 floating access, 1 integer-word store, 2 trap, 3 not handled. `done_valid` is high for exactly one cycle per accepted instruction.
- R2: Primary opcodes 48 through 55 are floating accesses in immediate form. In the opcode, bit value 4 selects a store (`mem_we`=1), bit value 2 selects an 8-byte access (`mem_dword`=1), and bit value 1 selects the update form.
- R3: Primary opcode 31 is a floating access in indexed form only when its extended opcode (instruction bits 10:1) masked with 0x31F equals 0x217. Within that extended opcode, 0x80 selects a store, 0x40 an 8-byte access and 0x20 update. Any other extended opcode, apart from those in R7 and R11, completes as kind 3 with no access.
- R4: The effective address is the sign-extended 16-bit displacement (bits 15:0) for immediate forms, or the rB value for indexed forms. The rA value is added only when the rA field (bits 20:16) is nonzero; a zero field adds nothing, whatever value is on the rA input.
- R5: An update form whose rA field is 0 completes one cycle after issue with `done_illegal`=1 and `done_kind`=0. It raises no memory request and writes neither register file.
- R6: An update form with a nonzero rA field writes the effective address to register rA (`gpr_we`, `gpr_idx`, `gpr_wdata`) in the completion cycle that follows the memory answer.
- R7: Opcode 31 with extended opcode 983 is an integer-word store (kind 1). It makes a 4-byte store (`mem_we`=1, `mem_dword`=0) whose data is the low 32 bits of the store image, zero-extended, and the address follows R4.
- R8: A 4-byte load writes its 32-bit single value to the floating register in double format. Normal values get their exponent rebiased by 896. Signed zeros stay signed zeros. Infinity and NaN get exponent 2047 with the fraction, including the quiet bit, shifted left by 29.
- R9: A 4-byte load of a single denormal is normalised. Its double exponent is 874 plus the position of the fraction's leading one, and the bits below that one fill the top of the double fraction.
- R10: An 8-byte load writes the returned 64 bits unchanged. An 8-byte store presents the full 64-bit store image on `mem_wdata`. A 4-byte store presents the low 32 bits zero-extended. Stores never write a floating register.
- R11: Primary opcode 3, or opcode 31 with extended opcode 4, completes as kind 2 one cycle after issue with no memory request and no register write.
- R12: `mem_req` stays high, with address, direction, size and data stable, until the cycle `mem_ack` is seen. Completion follows on the next cycle, and `issue_ready` is low from acceptance until completion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle and accepting |
| issue_insn | input | 32 | Instruction word |
| issue_ra_val | input | GPR_W | Value of the register named by the rA field |
| issue_rb_val | input | GPR_W | Value of the register named by the rB field |
| issue_st_data | input | 64 | Floating register image to store (already narrowed for single stores) |
| mem_req | output | 1 | Memory request, held until answered |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_dword | output | 1 | 1 = 8-byte access, 0 = 4-byte access |
| mem_addr | output | GPR_W | Effective address |
| mem_wdata | output | 64 | Store data |
| mem_ack | input | 1 | Memory answer for the pending request |
| mem_rdata | input | 64 | Load data, low 32 bits used for 4-byte loads |
| done_valid | output | 1 | Completion pulse |
| done_kind | output | 2 | Instruction class (R1) |
| done_illegal | output | 1 | Update form with zero base field |
| fpr_we | output | 1 | Floating register write enable |
| fpr_idx | output | 5 | Floating register index |
| fpr_wdata | output | 64 | Double-format load result |
| gpr_we | output | 1 | Base register write-back enable |
| gpr_idx | output | 5 | Base register index |
| gpr_wdata | output | GPR_W | Effective address for write-back |

## Verification
The assertions assume the memory side answers only while a request is pending and raises `mem_ack` for a single cycle per request. They also assume `issue_valid` is offered only while `issue_ready` is high. The bench meets both by driving `mem_ack` for one cycle after it has seen `mem_req`, at least one cycle late so that the hold rule is exercised. It also offers each instruction only from the idle state and drops `issue_valid` after one accepted cycle. The register values it supplies are chosen so that a wrongly applied zero-base rule, sign extension or rebias shows up in the address or data.

// File: rtl/fpls_pkg.sv
package fpls_pkg;

  localparam int REG_IDX_W = 5;
  localparam int DBL_W     = 64;
  localparam int SNG_W     = 32;
  localparam int DISP_W    = 16;

  // primary opcode values
  localparam logic [5:0] OPC_TRAP_IMM = 6'd3;
  localparam logic [5:0] OPC_EXT      = 6'd31;
  localparam logic [5:0] OPC_FPLS_LO  = 6'd48;
  localparam logic [5:0] OPC_FPLS_HI  = 6'd55;

  // extended opcode values under the extended primary opcode
  localparam logic [9:0] XO_TRAP       = 10'd4;
  localparam logic [9:0] XO_INT_ST     = 10'd983;
  localparam logic [9:0] XO_FPLS_MASK  = 10'h31F;
  localparam logic [9:0] XO_FPLS_MATCH = 10'h217;

  typedef enum logic [1:0] {
    KIND_FP     = 2'd0,
    KIND_INT_ST = 2'd1,
    KIND_TRAP   = 2'd2,
    KIND_NONE   = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e                 kind;
    logic                  store;
    logic                  dword;
    logic                  update;
    logic                  indexed;
    logic                  illegal;
    logic [REG_IDX_W-1:0]  rt;
    logic [REG_IDX_W-1:0]  ra;
    logic [DISP_W-1:0]     disp;
  } dec_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DONE   = 2'd2
  } state_e;

endpackage

// File: rtl/fpls_decode.sv
module fpls_decode
  import fpls_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);

  logic [5:0] opc;
  logic [9:0] xo;

  assign opc = insn[31:26];
  assign xo  = insn[10:1];

  always_comb begin
    dec         = '0;
    dec.kind    = KIND_NONE;
    dec.rt      = insn[25:21];
    dec.ra      = insn[20:16];
    dec.disp    = insn[15:0];
    if (opc == OPC_TRAP_IMM) begin
      dec.kind = KIND_TRAP;
    end else if (opc >= OPC_FPLS_LO && opc <= OPC_FPLS_HI) begin
      dec.kind   = KIND_FP;
      dec.store  = opc[2];
      dec.dword  = opc[1];
      dec.update = opc[0];
    end else if (opc == OPC_EXT) begin
      if (xo == XO_TRAP) begin
        dec.kind = KIND_TRAP;
      end else if (xo == XO_INT_ST) begin
        dec.kind    = KIND_INT_ST;
        dec.store   = 1'b1;
        dec.indexed = 1'b1;
      end else if ((xo & XO_FPLS_MASK) == XO_FPLS_MATCH) begin
        dec.kind    = KIND_FP;
        dec.store   = xo[7];
        dec.dword   = xo[6];
        dec.update  = xo[5];
        dec.indexed = 1'b1;
      end
    end
    dec.illegal = (dec.kind == KIND_FP) && dec.update && (dec.ra == '0);
  end

endmodule

// File: rtl/fpls_agen.sv
module fpls_agen
  import fpls_pkg::*;
#(
  parameter int GPR_W = 32
) (
  input  logic                 indexed,
  input  logic [REG_IDX_W-1:0] ra_idx,
  input  logic [DISP_W-1:0]    disp,
  input  logic [GPR_W-1:0]     ra_val,
  input  logic [GPR_W-1:0]     rb_val,
  output logic [GPR_W-1:0]     ea
);

  localparam int EXT_W = GPR_W - DISP_W;

  logic [GPR_W-1:0] base;
  logic [GPR_W-1:0] offset;

  always_comb begin
    base   = (ra_idx == '0) ? '0 : ra_val;
    offset = indexed ? rb_val : {{EXT_W{disp[DISP_W-1]}}, disp};
    ea     = base + offset;
  end

endmodule

// File: rtl/fpls_widen.sv
module fpls_widen
  import fpls_pkg::*;
(
  input  logic [SNG_W-1:0] sng,
  output logic [DBL_W-1:0] dbl
);

  localparam int SE_W   = 8;
  localparam int SF_W   = 23;
  localparam int DE_W   = 11;
  localparam int DF_W   = 52;
  localparam int PAD_W  = DF_W - SF_W;
  localparam logic [DE_W-1:0] REBIAS   = 11'd896;
  localparam logic [DE_W-1:0] DEN_BASE = 11'd874;

  logic              sgn;
  logic [SE_W-1:0]   sexp;
  logic [SF_W-1:0]   sfrac;
  logic [4:0]        lead;
  logic [SF_W:0]     shifted;
  logic [DE_W-1:0]   dexp;
  logic [DF_W-1:0]   dfrac;

  assign sgn   = sng[SNG_W-1];
  assign sexp  = sng[SNG_W-2:SF_W];
  assign sfrac = sng[SF_W-1:0];

  // leading-one position of the single fraction
  always_comb begin
    lead = '0;
    for (int i = 0; i < SF_W; i++) begin
      if (sfrac[i]) lead = 5'(i);
    end
    shifted = {1'b0, sfrac} << (5'(SF_W) - lead);
  end

  always_comb begin
    if (sexp == '1) begin
      dexp  = '1;
      dfrac = {sfrac, {PAD_W{1'b0}}};
    end else if (sexp == '0 && sfrac == '0) begin
      dexp  = '0;
      dfrac = '0;
    end else if (sexp == '0) begin
      dexp  = DEN_BASE + {6'd0, lead};
      dfrac = {shifted[SF_W-1:0], {PAD_W{1'b0}}};
    end else begin
      dexp  = {3'd0, sexp} + REBIAS;
      dfrac = {sfrac, {PAD_W{1'b0}}};
    end
  end

  assign dbl = {sgn, dexp, dfrac};

endmodule

// File: rtl/fpls_unit.sv
module fpls_unit
  import fpls_pkg::*;
#(
  parameter int GPR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_valid,
  output logic                 issue_ready,
  input  logic [31:0]          issue_insn,
  input  logic [GPR_W-1:0]     issue_ra_val,
  input  logic [GPR_W-1:0]     issue_rb_val,
  input  logic [DBL_W-1:0]     issue_st_data,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic                 mem_dword,
  output logic [GPR_W-1:0]     mem_addr,
  output logic [DBL_W-1:0]     mem_wdata,
  input  logic                 mem_ack,
  input  logic [DBL_W-1:0]     mem_rdata,
  output logic                 done_valid,
  output logic [1:0]           done_kind,
  output logic                 done_illegal,
  output logic                 fpr_we,
  output logic [REG_IDX_W-1:0] fpr_idx,
  output logic [DBL_W-1:0]     fpr_wdata,
  output logic                 gpr_we,
  output logic [REG_IDX_W-1:0] gpr_idx,
  output logic [GPR_W-1:0]     gpr_wdata
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  state_e           state_q, state_d;
  dec_t             dec_c, dec_q;
  logic [GPR_W-1:0] ea_c, ea_q;
  logic [DBL_W-1:0] wdata_c, wdata_q;
  logic [DBL_W-1:0] widened, ld_c, ld_q;
  logic             accept, cap_en, ld_en, needs_mem;

  fpls_decode u_decode (
    .insn (issue_insn),
    .dec  (dec_c)
  );

  fpls_agen #(.GPR_W(GPR_W)) u_agen (
    .indexed (dec_c.indexed),
    .ra_idx  (dec_c.ra),
    .disp    (dec_c.disp),
    .ra_val  (issue_ra_val),
    .rb_val  (issue_rb_val),
    .ea      (ea_c)
  );

  fpls_widen u_widen (
    .sng (mem_rdata[SNG_W-1:0]),
    .dbl (widened)
  );

  assign issue_ready = (state_q == ST_IDLE);
  assign accept      = issue_valid && issue_ready;
  assign needs_mem   = ((dec_c.kind == KIND_FP) && !dec_c.illegal) ||
                       (dec_c.kind == KIND_INT_ST);

  always_comb begin
    wdata_c = dec_c.dword ? issue_st_data
                          : {{(DBL_W-SNG_W){1'b0}}, issue_st_data[SNG_W-1:0]};
    ld_c    = dec_q.dword ? mem_rdata : widened;
    cap_en  = accept;
    ld_en   = (state_q == ST_ACCESS) && mem_ack;
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = needs_mem ? ST_ACCESS : ST_DONE;
      ST_ACCESS: if (mem_ack) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  // datapath registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (cap_en) begin
      dec_q   <= dec_c;
      ea_q    <= ea_c;
      wdata_q <= wdata_c;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) ld_q <= ld_c;
  end

  // outputs
  logic in_done, fp_ok;
  assign in_done = (state_q == ST_DONE);
  assign fp_ok   = (dec_q.kind == KIND_FP) && !dec_q.illegal;

  assign mem_req      = (state_q == ST_ACCESS);
  assign mem_we       = dec_q.store;
  assign mem_dword    = dec_q.dword;
  assign mem_addr     = ea_q;
  assign mem_wdata    = wdata_q;
  assign done_valid   = in_done;
  assign done_kind    = dec_q.kind;
  assign done_illegal = dec_q.illegal;
  assign fpr_we       = in_done && fp_ok && !dec_q.store;
  assign fpr_idx      = dec_q.rt;
  assign fpr_wdata    = ld_q;
  assign gpr_we       = in_done && fp_ok && dec_q.update;
  assign gpr_idx      = dec_q.ra;
  assign gpr_wdata    = ea_q;

endmodule

// File: rtl/fpls_unit_sva.sv
module fpls_unit_sva #(
  parameter int GPR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_valid,
  input logic             issue_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_dword,
  input logic [GPR_W-1:0] mem_addr,
  input logic             mem_ack,
  input logic             done_valid,
  input logic [1:0]       done_kind,
  input logic             done_illegal,
  input logic             fpr_we,
  input logic             gpr_we,
  input logic [4:0]       gpr_idx
);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_dword)));

  p_done_after_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (done_valid && !mem_req));

  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || done_valid) |-> !issue_ready);

  p_req_from_issue_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(issue_valid && issue_ready));

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  p_illegal_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_illegal) |-> (!fpr_we && !gpr_we && !mem_req));

  p_nonfp_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_kind != 2'd0) |-> (!fpr_we && !gpr_we));

  p_gpr_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we |-> (done_valid && gpr_idx != 5'd0));

  p_fpr_only_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fpr_we |-> (done_valid && done_kind == 2'd0));

endmodule

bind fpls_unit fpls_unit_sva #(.GPR_W(GPR_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .issue_valid  (issue_valid),
  .issue_ready  (issue_ready),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_dword    (mem_dword),
  .mem_addr     (mem_addr),
  .mem_ack      (mem_ack),
  .done_valid   (done_valid),
  .done_kind    (done_kind),
  .done_illegal (done_illegal),
  .fpr_we       (fpr_we),
  .gpr_we       (gpr_we),
  .gpr_idx      (gpr_idx)
);

// File: tb/fpls_unit_tb.sv
module fpls_unit_tb;

  localparam int  GPR_W  = 32;
  localparam time CLK_PERIOD = 10ns;

  logic              clk;
  logic              rst_n;
  logic              issue_valid;
  logic              issue_ready;
  logic [31:0]       issue_insn;
  logic [GPR_W-1:0]  issue_ra_val;
  logic [GPR_W-1:0]  issue_rb_val;
  logic [63:0]       issue_st_data;
  logic              mem_req;
  logic              mem_we;
  logic              mem_dword;
  logic [GPR_W-1:0]  mem_addr;
  logic [63:0]       mem_wdata;
  logic              mem_ack;
  logic [63:0]       mem_rdata;
  logic              done_valid;
  logic [1:0]        done_kind;
  logic              done_illegal;
  logic              fpr_we;
  logic [4:0]        fpr_idx;
  logic [63:0]       fpr_wdata;
  logic              gpr_we;
  logic [4:0]        gpr_idx;
  logic [GPR_W-1:0]  gpr_wdata;

  int checks = 0;
  int errors = 0;

  fpls_unit #(.GPR_W(GPR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_insn(issue_insn),
    .issue_ra_val(issue_ra_val), .issue_rb_val(issue_rb_val), .issue_st_data(issue_st_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_dword(mem_dword), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done_valid(done_valid), .done_kind(done_kind), .done_illegal(done_illegal),
    .fpr_we(fpr_we), .fpr_idx(fpr_idx), .fpr_wdata(fpr_wdata),
    .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_wdata(gpr_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dform(input logic [5:0] op, input logic [4:0] rt,
                                        input logic [4:0] ra, input logic [15:0] d);
    return {op, rt, ra, d};
  endfunction

  function automatic logic [31:0] xform(input logic [9:0] xo, input logic [4:0] rt,
                                        input logic [4:0] ra, input logic [4:0] rb);
    return {6'd31, rt, ra, rb, xo, 1'b0};
  endfunction

  // memory instruction: issue, observe a held request, answer, check completion
  task automatic mem_op(input string tag, input logic [31:0] insn,
                        input logic [31:0] ra_v, input logic [31:0] rb_v, input logic [63:0] st,
                        input logic [1:0] exp_kind, input logic exp_we, input logic exp_dw,
                        input logic [31:0] exp_addr, input logic [63:0] exp_wdata,
                        input logic [63:0] rdata, input logic exp_fwe, input logic [4:0] exp_fidx,
                        input logic [63:0] exp_fdata, input logic exp_gwe,
                        input logic [4:0] exp_gidx, input logic [31:0] exp_gdata);
    @(negedge clk);
    issue_valid = 1'b1; issue_insn = insn;
    issue_ra_val = ra_v; issue_rb_val = rb_v; issue_st_data = st;
    @(negedge clk);
    issue_valid = 1'b0;
    chk({tag, " R12 req"}, 64'(mem_req), 64'd1);
    chk({tag, " R12 ready low"}, 64'(issue_ready), 64'd0);
    chk({tag, " R2 we"}, 64'(mem_we), 64'(exp_we));
    chk({tag, " R2 dword"}, 64'(mem_dword), 64'(exp_dw));
    chk({tag, " R4 addr"}, 64'(mem_addr), 64'(exp_addr));
    if (exp_we) chk({tag, " R10 wdata"}, mem_wdata, exp_wdata);
    @(negedge clk);
    chk({tag, " R12 req held"}, 64'(mem_req), 64'd1);
    chk({tag, " R12 addr held"}, 64'(mem_addr), 64'(exp_addr));
    chk({tag, " R12 no early done"}, 64'(done_valid), 64'd0);
    mem_ack = 1'b1; mem_rdata = rdata;
    @(negedge clk);
    mem_ack = 1'b0;
    chk({tag, " R1 done"}, 64'(done_valid), 64'd1);
    chk({tag, " R1 kind"}, 64'(done_kind), 64'(exp_kind));
    chk({tag, " R5 illegal"}, 64'(done_illegal), 64'd0);
    chk({tag, " R12 req dropped"}, 64'(mem_req), 64'd0);
    chk({tag, " R10 fpr_we"}, 64'(fpr_we), 64'(exp_fwe));
    if (exp_fwe) begin
      chk({tag, " R8 fpr_idx"}, 64'(fpr_idx), 64'(exp_fidx));
      chk({tag, " R8 fpr data"}, fpr_wdata, exp_fdata);
    end
    chk({tag, " R6 gpr_we"}, 64'(gpr_we), 64'(exp_gwe));
    if (exp_gwe) begin
      chk({tag, " R6 gpr_idx"}, 64'(gpr_idx), 64'(exp_gidx));
      chk({tag, " R6 gpr data"}, 64'(gpr_wdata), 64'(exp_gdata));
    end
    @(negedge clk);
    chk({tag, " R1 single pulse"}, 64'(done_valid), 64'd0);
    chk({tag, " R12 ready again"}, 64'(issue_ready), 64'd1);
  endtask

  // instruction that completes without a memory access
  task automatic nomem_op(input string tag, input logic [31:0] insn,
                          input logic [1:0] exp_kind, input logic exp_ill);
    @(negedge clk);
    issue_valid = 1'b1; issue_insn = insn;
    issue_ra_val = 32'h5A5A_0000; issue_rb_val = 32'h0000_1234; issue_st_data = 64'h1;
    @(negedge clk);
    issue_valid = 1'b0;
    chk({tag, " done"}, 64'(done_valid), 64'd1);
    chk({tag, " kind"}, 64'(done_kind), 64'(exp_kind));
    chk({tag, " illegal"}, 64'(done_illegal), 64'(exp_ill));
    chk({tag, " no req"}, 64'(mem_req), 64'd0);
    chk({tag, " no fpr"}, 64'(fpr_we), 64'd0);
    chk({tag, " no gpr"}, 64'(gpr_we), 64'd0);
    @(negedge clk);
    chk({tag, " no req after"}, 64'(mem_req), 64'd0);
    chk({tag, " idle"}, 64'(issue_ready), 64'd1);
  endtask

  task automatic t_reset;
    chk("R12 reset ready", 64'(issue_ready), 64'd1);
    chk("R12 reset req", 64'(mem_req), 64'd0);
    chk("R1 reset done", 64'(done_valid), 64'd0);
  endtask

  task automatic t_immediate;
    mem_op("R8 lfs normal", dform(6'd48, 5'd3, 5'd5, 16'h0010), 32'h1000, 32'h0, 64'h0,
           2'd0, 1'b0, 1'b0, 32'h1010, 64'h0, 64'h0000_0000_3F80_0000,
           1'b1, 5'd3, 64'h3FF0_0000_0000_0000, 1'b0, 5'd0, 32'h0);
    mem_op("R10 lfd base0", dform(6'd50, 5'd9, 5'd0, 16'hFFF8), 32'h7777_0000, 32'h0, 64'h0,
           2'd0, 1'b0, 1'b1, 32'hFFFF_FFF8, 64'h0, 64'h0123_4567_89AB_CDEF,
           1'b1, 5'd9, 64'h0123_4567_89AB_CDEF, 1'b0, 5'd0, 32'h0);
    mem_op("R6 lfsu", dform(6'd49, 5'd2, 5'd7, 16'hFFFC), 32'h2000, 32'h0, 64'h0,
           2'd0, 1'b0, 1'b0, 32'h1FFC, 64'h0, 64'h0000_0000_C020_0000,
           1'b1, 5'd2, 64'hC004_0000_0000_0000, 1'b1, 5'd7, 32'h1FFC);
    mem_op("R2 stfdu", dform(6'd55, 5'd1, 5'd4, 16'h0020), 32'h0300, 32'h0, 64'hFEDC_BA98_7654_3210,
           2'd0, 1'b1, 1'b1, 32'h0320, 64'hFEDC_BA98_7654_3210, 64'h0,
           1'b0, 5'd0, 64'h0, 1'b1, 5'd4, 32'h0320);
    mem_op("R10 stfs", dform(6'd52, 5'd1, 5'd0, 16'h0040), 32'h9999_0000, 32'h0, 64'hDEAD_BEEF_CAFE_F00D,
           2'd0, 1'b1, 1'b0, 32'h0040, 64'h0000_0000_CAFE_F00D, 64'h0,
           1'b0, 5'd0, 64'h0, 1'b0, 5'd0, 32'h0);
  endtask

  task automatic t_indexed;
    mem_op("R3 lfsx", xform(10'd535, 5'd1, 5'd2, 5'd3), 32'h0100, 32'h0024, 64'h0,
           2'd0, 1'b0, 1'b0, 32'h0124, 64'h0, 64'h0000_0000_7FC0_0001,
           1'b1, 5'd1, 64'h7FF8_0000_2000_0000, 1'b0, 5'd0, 32'h0);
    mem_op("R3 lfdux", xform(10'd631, 5'd6, 5'd9, 5'd3), 32'h4000, 32'h0008, 64'h0,
           2'd0, 1'b0, 1'b1, 32'h4008, 64'h0, 64'h4000_0000_0000_0001,
           1'b1, 5'd6, 64'h4000_0000_0000_0001, 1'b1, 5'd9, 32'h4008);
    mem_op("R4 stfsx base0", xform(10'd663, 5'd1, 5'd0, 5'd3), 32'h5555_5555, 32'h0088, 64'h1111_2222_3333_4444,
           2'd0, 1'b1, 1'b0, 32'h0088, 64'h0000_0000_3333_4444, 64'h0,
           1'b0, 5'd0, 64'h0, 1'b0, 5'd0, 32'h0);
    mem_op("R3 stfdux", xform(10'd759, 5'd8, 5'd12, 5'd3), 32'h0800, 32'h0010, 64'hAAAA_BBBB_CCCC_DDDD,
           2'd0, 1'b1, 1'b1, 32'h0810, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0,
           1'b0, 5'd0, 64'h0, 1'b1, 5'd12, 32'h0810);
  endtask

  task automatic t_int_store;
    mem_op("R7 int word", xform(10'd983, 5'd4, 5'd2, 5'd3), 32'h0010, 32'h0100, 64'h8765_4321_0F0E_0D0C,
           2'd1, 1'b1, 1'b0, 32'h0110, 64'h0000_0000_0F0E_0D0C, 64'h0,
           1'b0, 5'd0, 64'h0, 1'b0, 5'd0, 32'h0);
  endtask

  task automatic t_specials;
    mem_op("R8 pos zero", dform(6'd48, 5'd10, 5'd1, 16'h0), 32'h10, 32'h0, 64'h0,
           2'd0, 1'b0, 1'b0, 32'h10, 64'h0, 64'h0,
           1'b1, 5'd10, 64'h0, 1'b0, 5'd0, 32'h0);
    mem_op("R8 neg zero", dform(6'd48, 5'd10, 5'd1, 16'h0), 32'h10, 32'h0, 64'h0,
           2'd0, 1'b0, 1'b0, 32'h10, 64'h0, 64'h0000_0000_8000_0000,
           1'b1, 5'd10, 64'h8000_0000_0000_0000, 1'b0, 5'd0, 32'h0);
    mem_op("R8 infinity", dform(6'd48, 5'd11, 5'd1, 16'h0), 32'h10, 32'h0, 64'h0,
           2'd0, 1'b0, 1'b0, 32'h10, 64'h0, 64'h0000_0000_7F80_0000,
           1'b1, 5'd11, 64'h7FF0_0000_0000_0000, 1'b0, 5'd0, 32'h0);
    mem_op("R9 min denormal", dform(6'd48, 5'd12, 5'd1, 16'h0), 32'h10, 32'h0, 64'h0,
           2'd0, 1'b0, 1'b0, 32'h10, 64'h0, 64'h0000_0000_0000_0001,
           1'b1, 5'd12, 64'h36A0_0000_0000_0000, 1'b0, 5'd0, 32'h0);
    mem_op("R9 top denormal", dform(6'd48, 5'd13, 5'd1, 16'h0), 32'h10, 32'h0, 64'h0,
           2'd0, 1'b0, 1'b0, 32'h10, 64'h0, 64'h0000_0000_0040_0000,
           1'b1, 5'd13, 64'h3800_0000_0000_0000, 1'b0, 5'd0, 32'h0);
    mem_op("R9 neg denormal", dform(6'd48, 5'd14, 5'd1, 16'h0), 32'h10, 32'h0, 64'h0,
           2'd0, 1'b0, 1'b0, 32'h10, 64'h0, 64'h0000_0000_8000_0003,
           1'b1, 5'd14, 64'hB6B8_0000_0000_0000, 1'b0, 5'd0, 32'h0);
  endtask

  task automatic t_illegal;
    nomem_op("R5 lfsu base0", dform(6'd49, 5'd3, 5'd0, 16'h0008), 2'd0, 1'b1);
    nomem_op("R5 stfdux base0", xform(10'd759, 5'd3, 5'd0, 5'd4), 2'd0, 1'b1);
  endtask

  task automatic t_trap_none;
    nomem_op("R11 trap imm", dform(6'd3, 5'd4, 5'd1, 16'h0010), 2'd2, 1'b0);
    nomem_op("R11 trap reg", xform(10'd4, 5'd4, 5'd1, 5'd2), 2'd2, 1'b0);
    nomem_op("R3 other xo", xform(10'd266, 5'd4, 5'd1, 5'd2), 2'd3, 1'b0);
    nomem_op("R1 opcode 63", dform(6'd63, 5'd4, 5'd1, 16'h0), 2'd3, 1'b0);
    nomem_op("R2 opcode 56", dform(6'd56, 5'd4, 5'd1, 16'h0), 2'd3, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; issue_valid = 1'b0; issue_insn = '0;
    issue_ra_val = '0; issue_rb_val = '0; issue_st_data = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_immediate();
    t_indexed();
    t_int_store();
    t_specials();
    t_illegal();
    t_trap_none();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule